// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block is the central scheduling record for a floating-point pipeline that issues in program order but lets operations run and finish out of order. Each cycle the front end offers one decoded instruction, made of an operation class, a destination register and two source registers. The controller chooses the functional unit for it and decides whether it may issue. After issue it tracks the instruction through operand read, execution and result write. There are five units: one load/integer unit, two multipliers, one adder/subtractor and one divider. Each unit here is a fixed-latency countdown that reports completion.

Registers are never renamed. Issue waits both for a busy unit and for a pending write to the same destination. Operand read waits until every source is produced. A finished result is held back while any other unit still has to read the old value of that register. The outputs are per-unit pulses that the datapath uses to read operands and write results, plus a stall back to the front end. A tag travels with each instruction, so the cycle of each of the four steps can be traced for every instruction.

Top module: `sb_issue_ctrl`

## Requirements
- R1: An offered instruction issues in the cycle it is offered only if its target unit is idle and no unit has a pending write to its destination. Otherwise `stall` is high, and the same instruction is held until it issues, so issue stays in program order.
- R2: Operation code 0 is load, 1 is add/subtract, 2 is multiply and 3 is divide. These go to units 0, 3, 1-or-2 and 4, reported as unit codes 1, 4, 2-or-3 and 5. A multiply takes unit 1 when that unit is idle, and unit 2 otherwise.
- R3: A unit is granted its operand read once all of its sources are available. The earliest read is the cycle after issue. Several units may read in the same cycle, and each instruction reads exactly once.
- R4: Execution completes `L` cycles after the read cycle, where `L` is 1 for load, 2 for add, 10 for multiply and 40 for divide.
- R5: A unit whose execution is complete does not write while another busy unit has a source equal to its destination that has not been read yet.
- R6: With no conflict, the write happens the cycle after completion. The write frees the unit and the destination register, and it marks that source ready in every unit waiting on it. A waiting unit can read in the next cycle, and a new instruction can issue to the freed unit in the next cycle.
- R7: Suppose an instruction issues in the same cycle that the producer of one of its sources writes. That source then counts as ready, and the instruction can read in the next cycle.
- R8: When several units are able to write in the same cycle, the lowest-numbered unit writes and the others wait at least one cycle.
- R9: After reset, all units are idle and no grant, issue or stall is asserted while nothing is offered.
- R10: The source fields of a load are not tracked. A load reads in the cycle after issue even if its source fields name registers that have pending writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_op | input | 2 | Operation class (see R2) |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| in_tag | input | TAG_W | Tag carried with the instruction |
| stall | output | 1 | Offered instruction cannot issue this cycle |
| issue_fire | output | 1 | Offered instruction issues this cycle |
| issue_unit | output | 3 | Unit code (1 to 5) chosen for the offered instruction |
| rd_grant | output | 5 | Per-unit operand read pulse |
| ex_done | output | 5 | Per-unit execution complete pulse |
| wb_grant | output | 5 | Per-unit result write pulse |
| fu_busy | output | 5 | Per-unit busy flag |
| fu_tag | output | 5*TAG_W | Tag of the instruction held by each unit |

## Verification
The bench builds the block with its default parameters: latencies of 1, 2, 10 and 40 cycles and a 4-bit tag. The 40-cycle divide waits on a multiply and then reads late, and this is what holds a finished add behind a read-before-write conflict for several cycles. The 1- and 2-cycle load and add latencies let two units finish in the same cycle, which exercises the write priority. The same two latencies also let a load write exactly while a dependent add issues, which exercises the same-cycle release.

// File: rtl/sb_pkg.sv
// Shared constants and types for the scoreboard controller.
// Assumes five units in a fixed order: load, mul0, mul1, add, div.
package sb_pkg;
    localparam int NFU  = 5;
    localparam int NREG = 16;
    localparam int RW   = $clog2(NREG);
    localparam int UW   = $clog2(NFU + 1);
    localparam int IW   = $clog2(NFU);

    localparam int U_LOAD = 0;
    localparam int U_MUL0 = 1;
    localparam int U_MUL1 = 2;
    localparam int U_ADD  = 3;
    localparam int U_DIV  = 4;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_ADD  = 2'd1,
        OP_MUL  = 2'd2,
        OP_DIV  = 2'd3
    } op_e;

    // Per-unit status record; a unit code of 0 in qj/qk means "no producer".
    typedef struct packed {
        logic          busy;
        op_e           op;
        logic [RW-1:0] fi;
        logic [RW-1:0] fj;
        logic [RW-1:0] fk;
        logic [UW-1:0] qj;
        logic [UW-1:0] qk;
        logic          rj;
        logic          rk;
        logic          fin;
    } fu_rec_t;
endpackage

// File: rtl/sb_fu_timer.sv
// Stub functional unit: a countdown loaded on the operand read pulse.
// Raises done in the cycle LAT cycles after the read cycle.
// Assumes start never arrives while a count is running.
module sb_fu_timer #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(LAT);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Completion is flagged on the last counted cycle.
    assign done = (cnt == CW'(1));

    assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt == '0));
    assert_done_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cnt == '0));
endmodule

// File: rtl/sb_wb_pick.sv
// Write-back arbiter: grants the lowest-numbered requesting unit.
// Purely combinational; assumes requests are stable within the cycle.
module sb_wb_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // Isolate the lowest set request bit.
    always_comb begin
        grant = req & (~req + N'(1));
    end
endmodule

// File: rtl/sb_issue_ctrl.sv
// Centralised scoreboard: in-order issue, out-of-order read/execute/write.
// Issue stalls on a busy unit or a pending writer of the destination;
// read waits for all sources; write waits while an unread older copy
// of the destination is still needed. No register renaming.
module sb_issue_ctrl
    import sb_pkg::*;
#(
    parameter int LAT_LOAD = 1,
    parameter int LAT_ADD  = 2,
    parameter int LAT_MUL  = 10,
    parameter int LAT_DIV  = 40,
    parameter int TAG_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           in_op,
    input  logic [3:0]           in_dst,
    input  logic [3:0]           in_src1,
    input  logic [3:0]           in_src2,
    input  logic [TAG_W-1:0]     in_tag,
    output logic                 stall,
    output logic                 issue_fire,
    output logic [2:0]           issue_unit,
    output logic [4:0]           rd_grant,
    output logic [4:0]           ex_done,
    output logic [4:0]           wb_grant,
    output logic [4:0]           fu_busy,
    output logic [5*TAG_W-1:0]   fu_tag
);
    fu_rec_t          fu    [NFU];
    logic [TAG_W-1:0] tag_q [NFU];
    logic [UW-1:0]    rstat [NREG];

    op_e           op_in;
    logic [IW-1:0] tgt;
    logic          can_issue;
    logic [UW-1:0] q_s1, q_s2;
    logic          byp1, byp2;
    fu_rec_t       new_rec;
    logic [NFU-1:0] war, wb_req;

    assign op_in = op_e'(in_op);

    // Pick the target unit for the offered instruction.
    always_comb begin
        case (op_in)
            OP_LOAD: tgt = IW'(U_LOAD);
            OP_ADD:  tgt = IW'(U_ADD);
            OP_DIV:  tgt = IW'(U_DIV);
            default: tgt = fu[U_MUL0].busy ? IW'(U_MUL1) : IW'(U_MUL0);
        endcase
    end

    // Issue decision: structural and destination-in-flight checks.
    assign can_issue  = in_valid && !fu[tgt].busy && (rstat[in_dst] == '0);
    assign issue_fire = can_issue;
    assign stall      = in_valid && !can_issue;
    assign issue_unit = UW'(tgt) + UW'(1);

    // Source producers, released if that producer writes this very cycle.
    always_comb begin
        q_s1 = rstat[in_src1];
        q_s2 = rstat[in_src2];
        byp1 = (q_s1 != '0) && wb_grant[IW'(q_s1 - UW'(1))];
        byp2 = (q_s2 != '0) && wb_grant[IW'(q_s2 - UW'(1))];
    end

    // Build the status record loaded into the target unit on issue.
    always_comb begin
        new_rec      = '0;
        new_rec.busy = 1'b1;
        new_rec.op   = op_in;
        new_rec.fi   = in_dst;
        new_rec.fj   = in_src1;
        new_rec.fk   = in_src2;
        new_rec.qj   = (op_in == OP_LOAD || byp1) ? '0 : q_s1;
        new_rec.qk   = (op_in == OP_LOAD || byp2) ? '0 : q_s2;
        new_rec.rj   = (new_rec.qj == '0);
        new_rec.rk   = (new_rec.qk == '0);
    end

    // Read-before-write conflict per finished unit.
    always_comb begin
        for (int u = 0; u < NFU; u++) begin
            war[u] = 1'b0;
            for (int f = 0; f < NFU; f++) begin
                if (f != u && fu[f].busy &&
                    ((fu[f].fj == fu[u].fi && fu[f].rj) ||
                     (fu[f].fk == fu[u].fi && fu[f].rk)))
                    war[u] = 1'b1;
            end
            wb_req[u]   = fu[u].fin && !war[u];
            rd_grant[u] = fu[u].busy && fu[u].rj && fu[u].rk;
        end
    end

    sb_wb_pick #(.N(NFU)) u_pick (.req(wb_req), .grant(wb_grant));

    // One countdown stub per unit, latency chosen by unit kind.
    for (genvar g = 0; g < NFU; g++) begin : g_unit
        localparam int L = (g == U_LOAD) ? LAT_LOAD :
                           (g == U_ADD)  ? LAT_ADD  :
                           (g == U_DIV)  ? LAT_DIV  : LAT_MUL;
        sb_fu_timer #(.LAT(L)) u_tmr (
            .clk(clk), .rst_n(rst_n), .start(rd_grant[g]), .done(ex_done[g]));
        assign fu_busy[g] = fu[g].busy;
        assign fu_tag[g*TAG_W +: TAG_W] = tag_q[g];

        assert_done_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ex_done[g] |-> (fu[g].busy && !fu[g].fin));
        assert_wb_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[g] |=> !fu_busy[g]);
        assert_read_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[g] |=> !rd_grant[g]);
    end

    // Scoreboard state update: read, wake-up, completion, write, issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int u = 0; u < NFU; u++) begin
                fu[u]    <= '0;
                tag_q[u] <= '0;
            end
            for (int r = 0; r < NREG; r++)
                rstat[r] <= '0;
        end else begin
            for (int u = 0; u < NFU; u++) begin
                if (rd_grant[u]) begin
                    fu[u].rj <= 1'b0;
                    fu[u].rk <= 1'b0;
                end
                for (int w = 0; w < NFU; w++) begin
                    if (wb_grant[w] && fu[u].qj == UW'(w + 1)) begin
                        fu[u].qj <= '0;
                        fu[u].rj <= 1'b1;
                    end
                    if (wb_grant[w] && fu[u].qk == UW'(w + 1)) begin
                        fu[u].qk <= '0;
                        fu[u].rk <= 1'b1;
                    end
                end
                if (ex_done[u])
                    fu[u].fin <= 1'b1;
                if (wb_grant[u]) begin
                    fu[u].busy <= 1'b0;
                    fu[u].fin  <= 1'b0;
                end
            end
            for (int w = 0; w < NFU; w++)
                if (wb_grant[w])
                    rstat[fu[w].fi] <= '0;
            if (issue_fire) begin
                fu[tgt]       <= new_rec;
                tag_q[tgt]    <= in_tag;
                rstat[in_dst] <= issue_unit;
            end
        end
    end

    assert_wb_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant));
    assert_dest_owned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |=> (rstat[$past(in_dst)] == $past(issue_unit)));
    assert_div_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fu[U_DIV].busy |-> (fu[U_DIV].op == OP_DIV));
endmodule

// File: tb/tb_sb_issue_ctrl.sv
`timescale 1ns/100ps
module tb_sb_issue_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = '0;
    logic [3:0]  in_dst = '0, in_src1 = '0, in_src2 = '0, in_tag = '0;
    logic        stall, issue_fire;
    logic [2:0]  issue_unit;
    logic [4:0]  rd_grant, ex_done, wb_grant, fu_busy;
    logic [19:0] fu_tag;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, n_stall = 0, base = 0;
    int iss [16], rdc [16], exc [16], wbc [16], unt [16];
    bit finished = 0;

    always #2.5 clk = ~clk;

    sb_issue_ctrl dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_tag(in_tag),
        .stall(stall), .issue_fire(issue_fire), .issue_unit(issue_unit),
        .rd_grant(rd_grant), .ex_done(ex_done), .wb_grant(wb_grant),
        .fu_busy(fu_busy), .fu_tag(fu_tag));

    // Event log: sampled 1 ns after each falling edge.
    always @(negedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            if (issue_fire) begin
                iss[in_tag] = cyc;
                unt[in_tag] = int'(issue_unit);
            end
            if (stall) n_stall++;
            for (int u = 0; u < 5; u++) begin
                if (rd_grant[u]) rdc[fu_tag[u*4 +: 4]] = cyc;
                if (ex_done[u])  exc[fu_tag[u*4 +: 4]] = cyc;
                if (wb_grant[u]) wbc[fu_tag[u*4 +: 4]] = cyc;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int i = 0; i < 16; i++) begin
            iss[i] = -1; rdc[i] = -1; exc[i] = -1; wbc[i] = -1; unt[i] = -1;
        end
        n_stall = 0;
    endtask

    // Offer one instruction and hold it until accepted.
    task automatic push(input logic [1:0] op, input logic [3:0] d, s1, s2, tg);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_dst = d; in_src1 = s1; in_src2 = s2; in_tag = tg;
        #1.5;
        while (stall) begin
            @(negedge clk);
            #1.5;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic int rel(input int a);
        return (a < 0) ? a : a - base;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        in_dst = 4'd7;
        repeat (3) @(negedge clk);
        #1.5;
        check("R9", "busy after reset", int'(fu_busy), 0);
        check("R9", "read grants", int'(rd_grant), 0);
        check("R9", "write grants", int'(wb_grant), 0);
        check("R9", "issue when idle", int'(issue_fire), 0);
        check("R9", "stall when idle", int'(stall), 0);
    endtask

    // Six-instruction sequence with RAW, WAR and structural waits.
    task automatic t_trace();
        int e_is [6] = '{1, 5, 6, 7, 8, 13};
        int e_rd [6] = '{2, 6, 9, 9, 21, 14};
        int e_ex [6] = '{3, 7, 19, 11, 61, 16};
        int e_wb [6] = '{4, 8, 20, 12, 62, 22};
        clear_log();
        push(2'd0, 4'd6, 4'd0, 4'd0, 4'd0);
        push(2'd0, 4'd2, 4'd0, 4'd0, 4'd1);
        push(2'd2, 4'd0, 4'd2, 4'd4, 4'd2);
        push(2'd1, 4'd8, 4'd6, 4'd2, 4'd3);
        push(2'd3, 4'd10, 4'd0, 4'd6, 4'd4);
        push(2'd1, 4'd6, 4'd8, 4'd2, 4'd5);
        idle(60);
        base = iss[0] - 1;
        for (int i = 0; i < 6; i++) begin
            check("R1", $sformatf("trace issue #%0d", i), rel(iss[i]), e_is[i]);
            check("R3", $sformatf("trace read #%0d", i), rel(rdc[i]), e_rd[i]);
            check("R4", $sformatf("trace exec #%0d", i), rel(exc[i]), e_ex[i]);
            check("R6", $sformatf("trace write #%0d", i), rel(wbc[i]), e_wb[i]);
        end
        check("R5", "add held behind unread divide source", rel(wbc[5]), 22);
        check("R2", "multiply unit code", unt[2], 2);
        check("R2", "divide unit code", unt[4], 5);
    endtask

    // Two multipliers fill, a third multiply waits for the first to free.
    task automatic t_dual_mul();
        clear_log();
        push(2'd2, 4'd1, 4'd2, 4'd3, 4'd0);
        push(2'd2, 4'd4, 4'd5, 4'd6, 4'd1);
        push(2'd2, 4'd7, 4'd2, 4'd3, 4'd2);
        idle(30);
        base = iss[0] - 1;
        check("R2", "first multiply unit", unt[0], 2);
        check("R2", "second multiply unit", unt[1], 3);
        check("R3", "second multiply read", rel(rdc[1]), 3);
        check("R1", "third multiply issue", rel(iss[2]), 14);
        check("R2", "third multiply unit", unt[2], 2);
    endtask

    // Destination still pending: issue waits for the earlier write.
    task automatic t_waw();
        clear_log();
        push(2'd1, 4'd1, 4'd10, 4'd11, 4'd0);
        push(2'd2, 4'd1, 4'd12, 4'd13, 4'd1);
        idle(20);
        base = iss[0] - 1;
        check("R1", "same-destination issue", rel(iss[1]), 6);
        check("R1", "stall cycles", n_stall, 4);
    endtask

    // Load and add finish together; load (unit 0) writes first.
    task automatic t_arb();
        clear_log();
        push(2'd1, 4'd9, 4'd10, 4'd11, 4'd0);
        push(2'd0, 4'd8, 4'd9, 4'd9, 4'd1);
        idle(10);
        base = iss[0] - 1;
        check("R10", "load reads despite pending source fields", rel(rdc[1]), 3);
        check("R4", "add completion", rel(exc[0]), 4);
        check("R8", "load write wins", rel(wbc[1]), 5);
        check("R8", "add write deferred", rel(wbc[0]), 6);
    endtask

    // Add issues in the cycle its source's load writes.
    task automatic t_bypass();
        clear_log();
        push(2'd1, 4'd9, 4'd10, 4'd11, 4'd0);
        idle(1);
        push(2'd0, 4'd3, 4'd0, 4'd0, 4'd1);
        push(2'd1, 4'd5, 4'd3, 4'd4, 4'd2);
        idle(15);
        base = iss[0] - 1;
        check("R7", "load write cycle", rel(wbc[1]), 6);
        check("R7", "dependent add issue", rel(iss[2]), 6);
        check("R7", "dependent add read", rel(rdc[2]), 7);
        check("R7", "dependent add write", rel(wbc[2]), 10);
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!finished) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL watchdog: actual timeout expected completion");
                    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
                    $finish;
                end
            end
        join_none
        t_reset();
        t_trace();
        t_dual_mul();
        t_waw();
        t_arb();
        t_bypass();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule